// File: doc/BRIEF.md
# ADC Conversion Sequencing Controller

This block is the digital control logic that sits beside a successive-approximation analog-to-digital converter. Software programs an 8-bit mode register that holds a two-bit conversion-speed code, an external-trigger enable and a four-bit input-channel code. A conversion starts on a one-cycle software start pulse or, when enabled, on an edge of an external trigger pin. The edge is chosen as rising or falling by a separate select input.

While a conversion runs, the block keeps a busy flag high for a fixed number of system clocks that depends on the speed code. It drives the channel number and a channel-valid flag to the analog multiplexer. When the count expires, it captures the converter's data word into a result register and raises a one-cycle done pulse. Start requests are dropped when the speed code is the reserved value or when no usable channel is selected. Channel writes are refused while a conversion is in progress.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the mode register reads 0x10, and busy, done and result are all 0.
- R2: The mode register reads back as {speed_hi, trig_en, speed_lo, 1'b1, chan[3:0]} in bits 7..0. Bit 4 always reads 1, whatever value is written to it.
- R3: The speed code is {bit 7, bit 5}. Code 01 keeps busy high for exactly 124 clocks, code 10 for 62 and code 11 for 31. The length is fixed at start, so a later write to the speed bits does not change the conversion in progress.
- R4: While the speed code is 00, a start request is dropped and busy stays 0.
- R5: Only channel codes 1000 to 1011 are usable. Codes 00xx, 01xx and 11xx drop any start request and leave busy at 0.
- R6: A write during busy updates bits 7, 6 and 5, but the channel field keeps its old value. When idle, the whole register is written.
- R7: chan_valid is 1 exactly when chan[3:2] is 10, and chan_sel outputs chan[1:0], so 1000 to 1011 map to inputs 4 to 7.
- R8: While trig_en is 0, edges on trig_in start nothing.
- R9: While trig_en is 1, an edge on trig_in of the polarity chosen by trig_rise_sel (1 for rising, 0 for falling) starts a conversion. busy rises on the third clock edge after the pin changes. Edges of the other polarity are ignored.
- R10: A software start or trigger edge that arrives while busy is ignored. It neither extends nor restarts the conversion.
- R11: In the cycle after busy falls, done is high for exactly one cycle and result holds the value of conv_data. result does not change at any other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Mode register write strobe |
| wr_data | input | 8 | Mode register write value |
| rd_data | output | 8 | Mode register read value |
| sw_start | input | 1 | Software start request, one cycle |
| trig_in | input | 1 | Asynchronous external trigger pin |
| trig_rise_sel | input | 1 | Trigger edge select: 1 rising, 0 falling |
| conv_data | input | 10 | Data word from the analog converter |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle end-of-conversion pulse |
| result | output | 10 | Captured conversion result |
| chan_sel | output | 2 | Multiplexer input index (0..3 for inputs 4..7) |
| chan_valid | output | 1 | A usable channel is selected |

## Verification
The trigger polarity assertion assumes that trig_rise_sel is steady while an edge moves through the two synchroniser stages. The stimulus therefore changes the select only after the pin has been quiet for several clocks. The result-hold and channel-lock properties assume nothing about conv_data or the write port. Because of this, the bench drives writes and data changes freely, including in the middle of a conversion. All inputs change on the falling clock edge, away from the sampling edge.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        SPD_RSVD = 2'b00,
        SPD_SLOW = 2'b01,
        SPD_MID  = 2'b10,
        SPD_FAST = 2'b11
    } spd_e;

    typedef struct packed {
        logic       spd_hi;
        logic       trig_en;
        logic       spd_lo;
        logic [3:0] chan;
    } mode_t;

    localparam logic [1:0] CHAN_GROUP_OK = 2'b10;

endpackage

// File: rtl/adc_mode_reg.sv
module adc_mode_reg
    import adc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic       busy,
    output mode_t      mode,
    output logic [7:0] rd_data
);

    mode_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.spd_hi  = wr_data[7];
            st_d.trig_en = wr_data[6];
            st_d.spd_lo  = wr_data[5];
            if (!busy) begin
                st_d.chan = wr_data[3:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mode    = st_q;
    assign rd_data = {st_q.spd_hi, st_q.trig_en, st_q.spd_lo, 1'b1, st_q.chan};

    // R6: channel field frozen across any cycle that starts busy
    p_chan_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (st_q.chan == $past(st_q.chan)));

endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic rise_sel,
    input  logic enable,
    output logic fire
);

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    sync_t st_d, st_q;
    logic  edge_rise, edge_fall;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign edge_rise = st_q.s2 & ~st_q.s3;
    assign edge_fall = ~st_q.s2 & st_q.s3;
    assign fire      = enable & (rise_sel ? edge_rise : edge_fall);

    // R9: a fire reflects the pin level of two samples earlier matching the chosen polarity
    p_fire_polarity_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ($past(pin, 2) == rise_sel));

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer
    import adc_seq_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int LEN_SLOW = 124,
    parameter int LEN_MID  = 62,
    parameter int LEN_FAST = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  spd_e              spd,
    input  logic [DATA_W-1:0] data_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result
);

    localparam int LEN_MAX = (LEN_SLOW > LEN_MID)
                           ? ((LEN_SLOW > LEN_FAST) ? LEN_SLOW : LEN_FAST)
                           : ((LEN_MID > LEN_FAST) ? LEN_MID : LEN_FAST);
    localparam int CNT_W = (LEN_MAX > 1) ? $clog2(LEN_MAX) : 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [CNT_W-1:0]  cnt;
        logic [DATA_W-1:0] result;
    } tmr_t;

    tmr_t             st_d, st_q;
    logic [CNT_W-1:0] load_val;

    always_comb begin
        case (spd)
            SPD_SLOW: load_val = CNT_W'(LEN_SLOW - 1);
            SPD_MID:  load_val = CNT_W'(LEN_MID - 1);
            SPD_FAST: load_val = CNT_W'(LEN_FAST - 1);
            default:  load_val = '0;
        endcase
    end

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.result = data_in;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
        end else if (start_req && (spd != SPD_RSVD)) begin
            st_d.busy = 1'b1;
            st_d.cnt  = load_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = st_q.busy;
    assign done   = st_q.done;
    assign result = st_q.result;

    // R11: done lasts one cycle
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R11: done only directly after busy falls
    p_done_after_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));
    // R11: result moves only together with done
    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
    import adc_seq_pkg::*;
#(
    parameter int DATA_W   = 10,
    parameter int LEN_SLOW = 124,
    parameter int LEN_MID  = 62,
    parameter int LEN_FAST = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    input  logic              sw_start,
    input  logic              trig_in,
    input  logic              trig_rise_sel,
    input  logic [DATA_W-1:0] conv_data,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result,
    output logic [1:0]        chan_sel,
    output logic              chan_valid
);

    mode_t mode;
    spd_e  spd;
    logic  trig_fire;
    logic  start_req;

    adc_mode_reg u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .busy    (busy),
        .mode    (mode),
        .rd_data (rd_data)
    );

    adc_trig_sync u_trig (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin      (trig_in),
        .rise_sel (trig_rise_sel),
        .enable   (mode.trig_en),
        .fire     (trig_fire)
    );

    assign spd        = spd_e'({mode.spd_hi, mode.spd_lo});
    assign chan_valid = (mode.chan[3:2] == CHAN_GROUP_OK);
    assign chan_sel   = mode.chan[1:0];
    assign start_req  = (sw_start | trig_fire) & chan_valid;

    adc_conv_timer #(
        .DATA_W   (DATA_W),
        .LEN_SLOW (LEN_SLOW),
        .LEN_MID  (LEN_MID),
        .LEN_FAST (LEN_FAST)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .spd       (spd),
        .data_in   (conv_data),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    // R4: no conversion begins under the reserved speed code
    p_no_rsvd_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> ($past(spd) != SPD_RSVD));
    // R5: no conversion begins without a usable channel
    p_valid_chan_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(chan_valid));

endmodule

// File: tb/tb_adc_seq_ctrl.sv
module tb_adc_seq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sw_start = 1'b0;
    logic       trig_in = 1'b0;
    logic       trig_rise_sel = 1'b1;
    logic [9:0] conv_data = '0;
    logic       busy, done, chan_valid;
    logic [9:0] result;
    logic [1:0] chan_sel;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    adc_seq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .sw_start(sw_start), .trig_in(trig_in), .trig_rise_sel(trig_rise_sel),
        .conv_data(conv_data), .busy(busy), .done(done), .result(result),
        .chan_sel(chan_sel), .chan_valid(chan_valid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic pulse_sw();
        @(negedge clk); sw_start = 1'b1;
        @(negedge clk); sw_start = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Counts busy cycles from the negedge where busy is first seen; optional injection.
    task automatic measure(input int inj_at, input int kind, output int n);
        n = 1;
        for (int g = 0; g < 400; g++) begin
            @(negedge clk);
            wr_en = 1'b0; sw_start = 1'b0;
            if (!busy) break;
            n++;
            if (n == inj_at) begin
                if (kind == 1) begin wr_en = 1'b1; wr_data = 8'h6B; end
                if (kind == 2) begin sw_start = 1'b1; trig_in = ~trig_in; end
            end
        end
    endtask

    function automatic int len_of(input int code);
        case (code)
            1: return 124;
            2: return 62;
            3: return 31;
            default: return 0;
        endcase
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        logic [9:0] expd;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 8'h10, "R1 rd_data", rd_data, 8'h10);
        chk(!busy && !done, "R1 busy/done", {busy, done}, 0);
        chk(result == '0, "R1 result", result, 0);

        // R2 and R7: full readback sweep while idle
        for (int v = 0; v < 256; v++) begin
            wr(8'(v));
            chk(rd_data == (8'(v) | 8'h10), "R2 readback", rd_data, v | 16);
            chk(chan_valid == (v[3:2] == 2'b10), "R7 chan_valid", chan_valid, int'(v[3:2] == 2'b10));
            if (v[3:2] == 2'b10)
                chk(chan_sel == v[1:0], "R7 chan_sel", chan_sel, v[1:0]);
        end

        // R3, R11: every speed code against every usable channel
        for (int code = 1; code < 4; code++) begin
            for (int ch = 8; ch < 12; ch++) begin
                wr({code[1], 1'b0, code[0], 1'b0, 4'(ch)});
                chk(chan_sel == 2'(ch - 8) && chan_valid, "R7 chan out", chan_sel, ch - 8);
                expd = 10'((code * 97 + ch * 53) % 1024);
                conv_data = expd;
                pulse_sw();
                chk(busy, "R3 busy after start", busy, 1);
                measure(0, 0, n);
                chk(n == len_of(code), "R3 busy length", n, len_of(code));
                chk(done, "R11 done at end", done, 1);
                chk(result == expd, "R11 result", result, expd);
                conv_data = ~expd;
                @(negedge clk);
                chk(!done, "R11 done one cycle", done, 0);
                idle(2);
                chk(result == expd, "R11 result held", result, expd);
            end
        end

        // R4: reserved speed code drops starts
        for (int ch = 8; ch < 12; ch++) begin
            wr({4'h0, 4'(ch)});
            pulse_sw();
            chk(!busy, "R4 no start", busy, 0);
            idle(3);
            chk(!busy && !done, "R4 stays idle", {busy, done}, 0);
        end

        // R5: unusable channels drop starts
        for (int ch = 0; ch < 16; ch++) begin
            if (ch >= 8 && ch < 12) continue;
            wr({4'hA, 4'(ch)});
            pulse_sw();
            chk(!busy, "R5 no start", busy, 0);
            chk(!chan_valid, "R5 chan_valid low", chan_valid, 0);
        end

        // R6, R3: write during busy (speed change must not alter length)
        wr(8'hA8);
        pulse_sw();
        measure(4, 1, n);
        chk(n == 31, "R3 latched length", n, 31);
        chk(rd_data == 8'h78, "R6 chan locked", rd_data, 8'h78);
        chk(chan_sel == 2'd0, "R6 chan_sel kept", chan_sel, 0);
        wr(8'h6B);
        chk(rd_data == 8'h7B, "R6 idle write", rd_data, 8'h7B);
        chk(chan_sel == 2'd3, "R6 chan_sel new", chan_sel, 3);

        // R8: trigger disabled
        wr(8'hA9);
        trig_rise_sel = 1'b1;
        @(negedge clk); trig_in = 1'b1;
        idle(4);
        chk(!busy, "R8 rising ignored", busy, 0);
        trig_in = 1'b0;
        idle(4);
        chk(!busy, "R8 falling ignored", busy, 0);

        // R9: rising edge start, latency of three edges
        wr(8'hE9);
        idle(3);
        trig_in = 1'b1;
        @(negedge clk); chk(!busy, "R9 latency 1", busy, 0);
        @(negedge clk); chk(!busy, "R9 latency 2", busy, 0);
        @(negedge clk); chk(busy, "R9 rising start", busy, 1);
        measure(0, 0, n);
        chk(n == 31, "R9 trig length", n, 31);
        idle(2);
        trig_in = 1'b0;
        idle(4);
        chk(!busy, "R9 falling ignored when rising chosen", busy, 0);
        trig_rise_sel = 1'b0;
        idle(2);
        trig_in = 1'b1;
        idle(4);
        chk(!busy, "R9 rising ignored when falling chosen", busy, 0);
        trig_in = 1'b0;
        @(negedge clk); @(negedge clk);
        chk(!busy, "R9 falling latency", busy, 0);
        @(negedge clk); chk(busy, "R9 falling start", busy, 1);
        measure(0, 0, n);
        chk(n == 31, "R9 falling length", n, 31);

        // R10: starts during busy ignored
        trig_rise_sel = 1'b1;
        idle(3);
        pulse_sw();
        measure(5, 2, n);
        chk(n == 31, "R10 no extension", n, 31);
        idle(4);
        chk(!busy, "R10 no restart", busy, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule